// File: doc/BRIEF.md
# Selectable Output Clock Generator

This block drives one clock out of the chip, taken from any of six internal clock sources. A control word picks the source. It also picks whether that source goes out unchanged or goes out divided by 2, 4 or 8. The division comes from one of the outputs of a three-stage ripple counter that runs on the chosen source. An enable bit in a separate register word gates the result. While the enable bit is clear, the output sits at logic 0.

Software sets up the generator through a small register port on the bus clock. There are two word addresses: one for the enable bit and one for the source and division fields. Both read back through the same port. The clock paths are purely combinational, apart from the ripple flops. The ripple flops are cleared while reset is high.

Top module: `outclk_gen`

## Requirements
- R1: Source select codes map to inputs as follows: code 0 is `src_clk[0]` (fast internal RC), 1 is `src_clk[1]` (crystal), 2 is `src_clk[2]` (primary PLL), 3 is `src_clk[3]` (secondary PLL), 4 is `src_clk[4]` (slow internal RC) and 5 is `src_clk[5]` (low-frequency crystal). With division 0, the output period equals the period of the chosen input.
- R2: With division select 0, the output copies the chosen source, so its high time equals the source's high time, whatever the duty cycle.
- R3: Division select 1, 2 and 3 give the source period multiplied by 2, 4 and 8 respectively, with a high time of exactly half the output period.
- R4: While the enable bit is 0, `clk_out` stays at 0 for every source and division setting.
- R5: Source select codes 6 to 15 choose no clock, and `clk_out` stays at 0 even when enabled.
- R6: Reset (synchronous, active high) clears the enable bit, the source select and the division select. Both register words then read as zero, and `clk_out` is low.
- R7: Address 0 holds the enable bit in bit 0. Address 1 holds the source select in bits 3:0 and the division select in bits 5:4. A write stores those bits, and a read returns them with every other bit as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rst | input | 1 | Synchronous active-high reset; also clears the ripple stages |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge of `clk` |
| bus_addr | input | 1 | Word address: 0 for enable, 1 for control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_clk | input | 6 | The six candidate source clocks, indexed by select code |
| clk_out | output | 1 | Gated, optionally divided output clock |

## Verification
The properties sample `clk_out` on the rising edge of the bus clock. They assume that the enable and select registers change only at that edge, so that a disabled or reserved setting holds across the whole sampling cycle. The readback property assumes that the address stays put for the cycle after a write. The bench writes and reads only at falling bus edges and holds the address after each write. It measures output edges in simulated time, away from the bus edges, and waits several output periods after each reconfiguration before measuring.

// File: rtl/outclk_pkg.sv
`timescale 1ns/1ps
package outclk_pkg;
    localparam int DATA_W    = 32;
    localparam int N_SRC     = 6;
    localparam int SRC_SEL_W = 4;
    localparam int N_STAGES  = 3;
    localparam int DIV_SEL_W = $clog2(N_STAGES + 1);
    localparam int CTRL_W    = SRC_SEL_W + DIV_SEL_W;

    typedef enum logic {
        ADDR_ENABLE = 1'b0,
        ADDR_CTRL   = 1'b1
    } reg_addr_e;

    // div occupies the upper field, src the lower one
    typedef struct packed {
        logic [DIV_SEL_W-1:0] div;
        logic [SRC_SEL_W-1:0] src;
    } ctrl_t;

    function automatic logic src_is_live(input logic [SRC_SEL_W-1:0] code);
        return int'(code) < N_SRC;
    endfunction
endpackage

// File: rtl/outclk_regs.sv
`timescale 1ns/1ps
module outclk_regs
    import outclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              oe,
    output ctrl_t             ctrl
);
    reg_addr_e sel;
    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            oe   <= 1'b0;
            ctrl <= '0;
        end else if (wr) begin
            if (sel == ADDR_ENABLE) oe   <= wdata[0];
            else                    ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_comb begin
        rdata = '0;
        if (sel == ADDR_ENABLE) rdata[0]          = oe;
        else                    rdata[CTRL_W-1:0] = ctrl;
    end
endmodule

// File: rtl/outclk_src_mux.sv
`timescale 1ns/1ps
module outclk_src_mux
    import outclk_pkg::*;
#(
    parameter int NS = N_SRC,
    parameter int SW = SRC_SEL_W
) (
    input  logic [NS-1:0] src_clk,
    input  logic [SW-1:0] sel,
    output logic          clk_sel,
    output logic          live
);
    always_comb begin
        clk_sel = 1'b0;
        for (int i = 0; i < NS; i++) begin
            if (int'(sel) == i) clk_sel = src_clk[i];
        end
    end

    assign live = src_is_live(sel);
endmodule

// File: rtl/outclk_ripple.sv
`timescale 1ns/1ps
module outclk_ripple
    import outclk_pkg::*;
#(
    parameter int NST = N_STAGES,
    parameter int DW  = DIV_SEL_W
) (
    input  logic          clk_in,
    input  logic          clr,
    input  logic [DW-1:0] tap_sel,
    output logic          tap
);
    logic [NST:0] chain;
    assign chain[0] = clk_in;

    for (genvar k = 0; k < NST; k++) begin : g_stage
        logic q;
        always_ff @(negedge chain[k] or posedge clr) begin
            if (clr) q <= 1'b0;
            else     q <= ~q;
        end
        assign chain[k+1] = q;
    end

    always_comb begin
        tap = 1'b0;
        for (int i = 0; i <= NST; i++) begin
            if (int'(tap_sel) == i) tap = chain[i];
        end
    end
endmodule

// File: rtl/outclk_gen.sv
`timescale 1ns/1ps
module outclk_gen
    import outclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  src_clk,
    output logic              clk_out
);
    logic                 oe_q;
    ctrl_t                ctrl_q;
    logic [SRC_SEL_W-1:0] src_sel;
    logic [DIV_SEL_W-1:0] div_sel;
    logic                 clk_mux;
    logic                 src_live;
    logic                 clk_tap;

    outclk_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .oe    (oe_q),
        .ctrl  (ctrl_q)
    );

    assign src_sel = ctrl_q.src;
    assign div_sel = ctrl_q.div;

    outclk_src_mux u_mux (
        .src_clk (src_clk),
        .sel     (src_sel),
        .clk_sel (clk_mux),
        .live    (src_live)
    );

    outclk_ripple u_div (
        .clk_in  (clk_mux),
        .clr     (rst),
        .tap_sel (div_sel),
        .tap     (clk_tap)
    );

    // a frozen ripple stage must not leak out when no source is chosen
    assign clk_out = oe_q & src_live & clk_tap;
endmodule

// File: rtl/outclk_checker.sv
`timescale 1ns/1ps
module outclk_checker
    import outclk_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic                 bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic                 clk_out,
    input logic                 oe,
    input logic [SRC_SEL_W-1:0] src_sel,
    input logic [DIV_SEL_W-1:0] div_sel
);
    a_r4_disabled_low: assert property (@(posedge clk) disable iff (rst)
        !oe |-> !clk_out);

    a_r5_reserved_low: assert property (@(posedge clk) disable iff (rst)
        (int'(src_sel) >= N_SRC) |-> !clk_out);

    a_r6_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!oe && src_sel == '0 && div_sel == '0));

    a_r7_ctrl_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr) |=>
            (!bus_addr || bus_rdata == DATA_W'($past(bus_wdata[CTRL_W-1:0]))));

    a_r7_enable_upper_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_addr |-> (bus_rdata[DATA_W-1:1] == '0));
endmodule

bind outclk_gen outclk_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .clk_out   (clk_out),
    .oe        (oe_q),
    .src_sel   (src_sel),
    .div_sel   (div_sel)
);

// File: tb/outclk_gen_test.sv
`timescale 1ns/1ps
module outclk_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int SRC_HI [6] = '{4, 5, 3, 6, 9, 11};
    localparam int SRC_LO [6] = '{4, 5, 4, 6, 9, 11};
    // stimulus: {source code, division select}
    localparam int VEC [12][2] = '{
        '{0, 0}, '{0, 3}, '{1, 1}, '{1, 2}, '{2, 0}, '{2, 1},
        '{2, 3}, '{3, 2}, '{3, 0}, '{4, 1}, '{5, 0}, '{5, 3}};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  src_clk;
    logic        clk_out;
    int          n_checks = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar g = 0; g < 6; g++) begin : g_src
        logic c = 1'b0;
        initial forever begin
            #(SRC_LO[g]) c = 1'b1;
            #(SRC_HI[g]) c = 1'b0;
        end
        assign src_clk[g] = c;
    end

    outclk_gen uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_clk   (src_clk),
        .clk_out   (clk_out)
    );

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // counts samples at which the output is high over a window
    task automatic high_samples(output int n);
        n = 0;
        #0.5;
        for (int i = 0; i < 300; i++) begin
            if (clk_out) n++;
            #1;
        end
    endtask

    task automatic measure(output longint per, output longint hi);
        longint t0, t1, t2;
        @(posedge clk_out); t0 = longint'($time);
        @(negedge clk_out); t1 = longint'($time);
        @(posedge clk_out); t2 = longint'($time);
        per = t2 - t0;
        hi  = t1 - t0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;
        longint per, hi, eper, ehi;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R6: state after reset
        rd(1'b0, d); check(d == 0, "R6 enable word", d, 0);
        rd(1'b1, d); check(d == 0, "R6 control word", d, 0);
        high_samples(n); check(n == 0, "R6 output low", n, 0);

        // R7: field placement and zero unused bits
        wr(1'b1, 32'hFFFF_FF3A);
        rd(1'b1, d); check(d == 32'h3A, "R7 control readback", d, 32'h3A);
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, d); check(d == 32'h1, "R7 enable readback", d, 1);

        // R5: reserved code 10 while enabled
        high_samples(n); check(n == 0, "R5 code 10 low", n, 0);

        // R1 R2 R3: source and division sweep
        foreach (VEC[v]) begin
            wr(1'b1, 32'(VEC[v][0] | (VEC[v][1] << 4)));
            #400;
            measure(per, hi);
            eper = longint'(SRC_HI[VEC[v][0]] + SRC_LO[VEC[v][0]]) << VEC[v][1];
            ehi  = (VEC[v][1] == 0) ? longint'(SRC_HI[VEC[v][0]]) : eper / 2;
            if (VEC[v][1] == 0) begin
                check(per == eper, "R1 period", per, eper);
                check(hi == ehi, "R2 high time", hi, ehi);
            end else begin
                check(per == eper, "R3 period", per, eper);
                check(hi == ehi, "R3 high time", hi, ehi);
            end
        end

        // R4: disable forces low
        wr(1'b1, 32'h01);
        wr(1'b0, 32'h0);
        high_samples(n); check(n == 0, "R4 disabled src1", n, 0);
        wr(1'b1, 32'h34);
        high_samples(n); check(n == 0, "R4 disabled src4 div8", n, 0);

        // R5: reserved boundary codes with enable set
        wr(1'b0, 32'h1);
        wr(1'b1, 32'h16);
        high_samples(n); check(n == 0, "R5 code 6 low", n, 0);
        wr(1'b1, 32'h0F);
        high_samples(n); check(n == 0, "R5 code 15 low", n, 0);

        // R6: reset in the middle of operation
        wr(1'b1, 32'h21);
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd(1'b0, d); check(d == 0, "R6 enable after reset", d, 0);
        rd(1'b1, d); check(d == 0, "R6 control after reset", d, 0);
        high_samples(n); check(n == 0, "R6 output after reset", n, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule